// File: doc/BRIEF.md
# Programmable SPI Frame Shifter

This block moves one serial frame in both directions at once. A sequencer gives it a parallel transmit word and a one-cycle start strobe. A separate clock generator supplies one tick for every SCK edge. The block drives the transmit line and the SCK level, and it captures the receive line on the selected edge. When the final edge has passed, it returns the received word, a one-cycle completion pulse and a parity mismatch flag.

The settings are frame length, parity, bit order, sampling edge and SCK idle level. They are captured when a frame starts. Between frames the transmit line follows a selectable idle policy, and one of those policies releases the line to high impedance through an output enable. Clock division, chip-select timing, buffering and register access are handled by neighbouring blocks.

Top module: `spi_frame_serializer`

## Requirements
- R1: The data length is `cfgDataLen`, clamped to 8..32 when `cfgParEn`=0 and to 7..31 when `cfgParEn`=1. A frame has data length + `cfgParEn` bits, and each bit takes two accepted edge ticks.
- R2: With `cfgMsbFirst`=1 the data bits go out and come in most significant bit first. With `cfgMsbFirst`=0 they go least significant bit first.
- R3: With parity on, one parity bit follows the last data bit. When `cfgParOdd`=0 it makes the number of ones across data and parity even, and when `cfgParOdd`=1 it makes that number odd.
- R4: `parityErr` is updated together with `done`. It is 1 only if parity was on and the received parity bit broke the selected rule, and it holds its value until the next `done`.
- R5: Edge ticks of a frame are counted from 0. With `cfgSampleSecond`=0, RXD is sampled on even ticks and TXD changes on odd ticks. With `cfgSampleSecond`=1, RXD is sampled on odd ticks and TXD changes on even ticks other than tick 0. Bit 0 is on TXD from the cycle after start.
- R6: SCK equals `cfgSckIdleHigh` while idle. During a frame it starts at the idle level and inverts on every accepted tick.
- R7: While idle, `cfgIdleMode` sets TXD as follows: 0 gives high, 1 gives low, 2 holds the last bit of the previous frame, and 3 drops `txdOe` to 0. `txdOe` is 1 in all other cases.
- R8: `rxWord` holds the received data bits right-aligned and zero-extended, excluding parity. It is updated only with `done` and holds its value otherwise.
- R9: Settings and `txWord` are captured at start. Changes to them, and any start strobe that arrives while busy, have no effect on the frame in progress.
- R10: A start that arrives in the same cycle as the final tick begins the next frame back to back. In that case `busy` stays 1 and the new bit 0 appears on TXD.
- R11: `done` is a one-cycle pulse in the cycle after the final tick. `busy` is 1 from the cycle after start until that same cycle, and edge ticks received while idle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Frame start strobe |
| txWord | input | 32 | Word to transmit, right-aligned |
| cfgDataLen | input | 6 | Requested data length in bits |
| cfgParEn | input | 1 | Append parity bit |
| cfgParOdd | input | 1 | 1 selects odd parity, 0 selects even |
| cfgMsbFirst | input | 1 | 1 sends MSB first, 0 sends LSB first |
| cfgSampleSecond | input | 1 | 1 samples on the second edge of each bit |
| cfgSckIdleHigh | input | 1 | SCK idle level |
| cfgIdleMode | input | 2 | TXD idle policy (0 high, 1 low, 2 hold, 3 released) |
| edgeTick | input | 1 | One pulse per SCK edge |
| rxd | input | 1 | Serial receive data |
| txd | output | 1 | Serial transmit data |
| txdOe | output | 1 | Output enable for TXD |
| sck | output | 1 | Serial clock level |
| busy | output | 1 | Frame in progress |
| rxWord | output | 32 | Received word |
| done | output | 1 | Frame complete pulse |
| parityErr | output | 1 | Received parity mismatch |

## Verification
Frame completion and the start of the next frame can land in the same cycle. To provoke this, the bench raises a new start, with different settings and a different word, together with the final edge tick. In that one cycle it checks that `done`, `rxWord` and `parityErr` belong to the old frame, while `busy` and TXD already reflect bit 0 of the new frame. It then runs the new frame without another start, checking every bit against its own settings.

// File: rtl/spi_ser_pkg.sv
package spi_ser_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W = $clog2(WORD_W) + 1;
  localparam int CNT_W = LEN_W + 1;

  typedef struct packed {
    logic [LEN_W-1:0] dataLen;
    logic parEn;
    logic parOdd;
    logic msbFirst;
    logic sckIdleHigh;
  } frameCfgT;

  typedef struct packed {
    logic load;
    logic tick;
    logic launch;
    logic sample;
    logic finish;
  } strobeT;

  function automatic logic [LEN_W-1:0] effLen(input logic [LEN_W-1:0] req, input logic parEn);
    logic [LEN_W-1:0] lo, hi;
    lo = parEn ? LEN_W'(7) : LEN_W'(8);
    hi = parEn ? LEN_W'(WORD_W - 1) : LEN_W'(WORD_W);
    if (req < lo) return lo;
    else if (req > hi) return hi;
    else return req;
  endfunction
endpackage

// File: rtl/spi_ser_ctrl.sv
module spi_ser_ctrl
  import spi_ser_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic edgeTick,
  input  logic [LEN_W-1:0] frameBits,
  input  logic sampleSecond,
  output strobeT stb,
  output logic busy
);
  logic busyQ, s2Q;
  logic [CNT_W-1:0] edgeQ, lastEdgeQ;
  logic tickB, finish;

  assign tickB  = busyQ & edgeTick;
  assign finish = tickB & (edgeQ == lastEdgeQ);

  always_comb begin
    stb.tick   = tickB;
    stb.finish = finish;
    stb.load   = start & (~busyQ | finish);
    stb.sample = tickB & (edgeQ[0] == s2Q);
    stb.launch = tickB & ~finish &
                 (s2Q ? (~edgeQ[0] && edgeQ != '0) : edgeQ[0]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ     <= 1'b0;
      s2Q       <= 1'b0;
      edgeQ     <= '0;
      lastEdgeQ <= '0;
    end else if (stb.load) begin
      busyQ     <= 1'b1;
      s2Q       <= sampleSecond;
      edgeQ     <= '0;
      lastEdgeQ <= ({1'b0, frameBits} << 1) - CNT_W'(1);
    end else if (finish) begin
      busyQ <= 1'b0;
    end else if (tickB) begin
      edgeQ <= edgeQ + CNT_W'(1);
    end
  end

  assign busy = busyQ;
endmodule

// File: rtl/spi_ser_datapath.sv
module spi_ser_datapath
  import spi_ser_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  strobeT stb,
  input  frameCfgT cfgIn,
  input  logic [WORD_W-1:0] txWord,
  input  logic rxd,
  input  logic busy,
  input  logic [1:0] idleMode,
  input  logic sckIdleLive,
  output logic txd,
  output logic txdOe,
  output logic sck,
  output logic [WORD_W-1:0] rxWord,
  output logic done,
  output logic parityErr
);
  logic [WORD_W-1:0] wordQ, rxAccQ, rxWordQ, lenMask, rxAccNext, finalAcc;
  logic [LEN_W-1:0] lenQ, idxQ, posMsb;
  logic parEnQ, parOddQ, msbQ, rxParQ, perrQ, sckQ, lastBitQ, doneQ, perrOutQ;
  logic isData, curBit, txPar, mismatch, finalErr;
  logic [WORD_W:0] maskWide;

  assign maskWide  = ((WORD_W+1)'(1) << lenQ) - (WORD_W+1)'(1);
  assign lenMask   = maskWide[WORD_W-1:0];
  assign isData    = idxQ < lenQ;
  assign posMsb    = lenQ - idxQ - LEN_W'(1);
  assign txPar     = (^(wordQ & lenMask)) ^ parOddQ;
  assign curBit    = isData ? (msbQ ? wordQ[posMsb[LEN_W-2:0]] : wordQ[idxQ[LEN_W-2:0]]) : txPar;
  assign rxAccNext = msbQ ? {rxAccQ[WORD_W-2:0], rxd} : (rxAccQ | (WORD_W'(rxd) << idxQ));
  assign mismatch  = rxd != (rxParQ ^ parOddQ);
  assign finalAcc  = (stb.sample && isData) ? rxAccNext : rxAccQ;
  assign finalErr  = parEnQ & ((stb.sample && !isData) ? mismatch : perrQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordQ <= '0; lenQ <= LEN_W'(8); parEnQ <= 1'b0; parOddQ <= 1'b0; msbQ <= 1'b0;
      idxQ <= '0; rxAccQ <= '0; rxParQ <= 1'b0; perrQ <= 1'b0; sckQ <= 1'b0;
    end else if (stb.load) begin
      wordQ   <= txWord;
      lenQ    <= cfgIn.dataLen;
      parEnQ  <= cfgIn.parEn;
      parOddQ <= cfgIn.parOdd;
      msbQ    <= cfgIn.msbFirst;
      sckQ    <= cfgIn.sckIdleHigh;
      idxQ    <= '0;
      rxAccQ  <= '0;
      rxParQ  <= 1'b0;
      perrQ   <= 1'b0;
    end else begin
      if (stb.tick) sckQ <= ~sckQ;
      if (stb.launch) idxQ <= idxQ + LEN_W'(1);
      if (stb.sample) begin
        if (isData) begin
          rxAccQ <= rxAccNext;
          rxParQ <= rxParQ ^ rxd;
        end else begin
          perrQ <= mismatch;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneQ <= 1'b0; rxWordQ <= '0; perrOutQ <= 1'b0; lastBitQ <= 1'b1;
    end else begin
      doneQ <= stb.finish;
      if (stb.finish) begin
        rxWordQ  <= finalAcc;
        perrOutQ <= finalErr;
        lastBitQ <= curBit;
      end
    end
  end

  always_comb begin
    txdOe = 1'b1;
    if (busy) txd = curBit;
    else begin
      unique case (idleMode)
        2'd0: txd = 1'b1;
        2'd1: txd = 1'b0;
        2'd2: txd = lastBitQ;
        default: begin txd = 1'b0; txdOe = 1'b0; end
      endcase
    end
  end

  assign sck       = busy ? sckQ : sckIdleLive;
  assign rxWord    = rxWordQ;
  assign done      = doneQ;
  assign parityErr = perrOutQ;
endmodule

// File: rtl/spi_frame_serializer.sv
module spi_frame_serializer
  import spi_ser_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic [31:0] txWord,
  input  logic [5:0] cfgDataLen,
  input  logic cfgParEn,
  input  logic cfgParOdd,
  input  logic cfgMsbFirst,
  input  logic cfgSampleSecond,
  input  logic cfgSckIdleHigh,
  input  logic [1:0] cfgIdleMode,
  input  logic edgeTick,
  input  logic rxd,
  output logic txd,
  output logic txdOe,
  output logic sck,
  output logic busy,
  output logic [31:0] rxWord,
  output logic done,
  output logic parityErr
);
  frameCfgT cfgEff;
  strobeT stb;
  logic [LEN_W-1:0] frameBits;

  always_comb begin
    cfgEff.dataLen     = effLen(cfgDataLen, cfgParEn);
    cfgEff.parEn       = cfgParEn;
    cfgEff.parOdd      = cfgParOdd;
    cfgEff.msbFirst    = cfgMsbFirst;
    cfgEff.sckIdleHigh = cfgSckIdleHigh;
  end
  assign frameBits = cfgEff.dataLen + LEN_W'(cfgParEn);

  spi_ser_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .edgeTick(edgeTick),
    .frameBits(frameBits), .sampleSecond(cfgSampleSecond),
    .stb(stb), .busy(busy)
  );

  spi_ser_datapath i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cfgIn(cfgEff), .txWord(txWord),
    .rxd(rxd), .busy(busy), .idleMode(cfgIdleMode), .sckIdleLive(cfgSckIdleHigh),
    .txd(txd), .txdOe(txdOe), .sck(sck), .rxWord(rxWord),
    .done(done), .parityErr(parityErr)
  );
endmodule

// File: rtl/spi_ser_chk.sv
module spi_ser_chk (
  input logic clk,
  input logic rstN,
  input logic edgeTick,
  input logic cfgSckIdleHigh,
  input logic [1:0] cfgIdleMode,
  input logic txd,
  input logic txdOe,
  input logic sck,
  input logic busy,
  input logic done,
  input logic parityErr
);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  // R11
  busy_end_done_chk: assert property (@(posedge clk) disable iff (!rstN) $fell(busy) |-> done);
  // R7
  oe_busy_chk: assert property (@(posedge clk) disable iff (!rstN) busy |-> txdOe);
  // R7
  idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cfgIdleMode == 2'd1) |-> (!txd && txdOe));
  // R6
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rstN) !busy |-> sck == cfgSckIdleHigh);
  // R5
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !$past(edgeTick)) |-> ($stable(txd) && $stable(sck)));
  // R4
  perr_stable_chk: assert property (@(posedge clk) disable iff (!rstN) !done |-> $stable(parityErr));
endmodule

bind spi_frame_serializer spi_ser_chk i_chk (
  .clk(clk), .rstN(rstN), .edgeTick(edgeTick), .cfgSckIdleHigh(cfgSckIdleHigh),
  .cfgIdleMode(cfgIdleMode), .txd(txd), .txdOe(txdOe), .sck(sck), .busy(busy),
  .done(done), .parityErr(parityErr)
);

// File: tb/test_spi_frame_serializer.sv
module test_spi_frame_serializer;
  logic clk = 0, rstN = 0, start = 0, cfgParEn = 0, cfgParOdd = 0, cfgMsbFirst = 1;
  logic cfgSampleSecond = 0, cfgSckIdleHigh = 0, edgeTick = 0, rxd = 0;
  logic [31:0] txWord = 0;
  logic [5:0] cfgDataLen = 8;
  logic [1:0] cfgIdleMode = 0;
  logic txd, txdOe, sck, busy, done, parityErr;
  logic [31:0] rxWord;
  int checks = 0, failures = 0;
  bit finished = 0;
  logic lastTx;
  // settings for a chained frame
  int nLen, nPar, nOdd, nMsb, nS2, nCkh;
  logic [31:0] nWord;

  always #5 clk = ~clk;

  spi_frame_serializer i_spi_frame_serializer (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int clampLen(int l, int p);
    int lo = p ? 7 : 8;
    int hi = p ? 31 : 32;
    return (l < lo) ? lo : (l > hi) ? hi : l;
  endfunction

  function automatic logic [31:0] lenMask(int l);
    return (l >= 32) ? 32'hFFFF_FFFF : ((32'h1 << l) - 1);
  endfunction

  function automatic logic frameBit(logic [31:0] w, int l, int odd, int msb, int k);
    if (k < l) return msb ? w[l-1-k] : w[k];
    return (^(w & lenMask(l))) ^ odd[0];
  endfunction

  task automatic frame(input int len, par, odd, msb, s2, ckh, input logic [31:0] w, rdw,
                       input bit corrupt, disturb, chain, noStart, input string tag);
    int l = clampLen(len, par);
    int n = l + par;
    bit txOk = 1;
    if (!noStart) begin
      @(negedge clk);
      cfgDataLen = 6'(len); cfgParEn = par[0]; cfgParOdd = odd[0]; cfgMsbFirst = msb[0];
      cfgSampleSecond = s2[0]; cfgSckIdleHigh = ckh[0]; txWord = w; start = 1;
      @(negedge clk); start = 0;
      chk(busy == 1, {"R11 busy after start ", tag}, 32'(busy), 1);
    end
    for (int e = 0; e < 2*n; e++) begin
      int idx = s2 ? ((e == 0) ? 0 : (e - 1) / 2) : e / 2;
      logic rb;
      repeat (2) @(negedge clk);
      // R5 / R2 / R3: TXD bit before each tick
      if (txd !== frameBit(w, l, odd, msb, idx)) txOk = 0;
      if (sck !== (ckh[0] ^ e[0])) txOk = 0;
      rb = frameBit(rdw, l, odd, msb, e / 2);
      if (e / 2 == l && corrupt) rb = ~rb;
      rxd = rb;
      if (disturb && e == 3) begin
        cfgMsbFirst = ~msb[0]; txWord = ~w; cfgDataLen = 6'd20; start = 1;
        @(negedge clk); start = 0;
      end
      edgeTick = 1;
      if (chain && e == 2*n-1) begin
        cfgDataLen = 6'(nLen); cfgParEn = nPar[0]; cfgParOdd = nOdd[0]; cfgMsbFirst = nMsb[0];
        cfgSampleSecond = nS2[0]; cfgSckIdleHigh = nCkh[0]; txWord = nWord; start = 1;
      end
      @(negedge clk); edgeTick = 0; start = 0;
    end
    chk(txOk, {"R5 R2 R3 R6 serial bits and sck ", tag}, 32'(txOk), 1);
    chk(done == 1, {"R11 done after final tick ", tag}, 32'(done), 1);
    chk(rxWord == (rdw & lenMask(l)), {"R8 R2 received word ", tag}, rxWord, rdw & lenMask(l));
    chk(parityErr == (corrupt && par != 0), {"R4 parity flag ", tag}, 32'(parityErr), 32'(corrupt && par != 0));
    if (chain) begin
      chk(busy == 1, {"R10 busy stays for chained frame ", tag}, 32'(busy), 1);
      chk(txd == frameBit(nWord, clampLen(nLen, nPar), nOdd, nMsb, 0),
          {"R10 new bit 0 on txd ", tag}, 32'(txd), 32'(frameBit(nWord, clampLen(nLen, nPar), nOdd, nMsb, 0)));
    end else begin
      chk(busy == 0, {"R11 idle after frame ", tag}, 32'(busy), 0);
    end
    lastTx = frameBit(w, l, odd, msb, n - 1);
    @(negedge clk);
    chk(done == 0, {"R11 done single cycle ", tag}, 32'(done), 0);
  endtask

  task automatic testReset();
    chk(busy == 0 && done == 0, "R11 reset idle", {busy, done}, 0);
    chk(txd == 1 && txdOe == 1, "R7 reset idle high", {txd, txdOe}, 2'b11);
    chk(sck == 0, "R6 reset sck idle", 32'(sck), 0);
    chk(rxWord == 0 && parityErr == 0, "R8 R4 reset outputs", rxWord, 0);
  endtask

  task automatic testIdleModes();
    @(negedge clk); cfgIdleMode = 2;
    @(negedge clk); chk(txd == lastTx && txdOe, "R7 hold last bit", 32'(txd), 32'(lastTx));
    cfgIdleMode = 1;
    @(negedge clk); chk(txd == 0 && txdOe, "R7 idle low", 32'(txd), 0);
    cfgIdleMode = 3;
    @(negedge clk); chk(txdOe == 0, "R7 released", 32'(txdOe), 0);
    cfgIdleMode = 0;
    @(negedge clk); chk(txd == 1 && txdOe, "R7 idle high", 32'(txd), 1);
    cfgSckIdleHigh = 1;
    for (int i = 0; i < 5; i++) begin
      edgeTick = 1; @(negedge clk); edgeTick = 0; @(negedge clk);
    end
    chk(busy == 0 && sck == 1 && done == 0, "R11 R6 ticks ignored when idle", {busy, sck, done}, 3'b010);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    frame(8, 0, 0, 1, 0, 0, 32'h0000_00A5, 32'h0000_003C, 0, 0, 0, 0, "R1 msb 8bit");
    frame(32, 0, 0, 0, 1, 1, 32'hDEAD_BEEF, 32'h1234_5678, 0, 0, 0, 0, "R5 lsb 32bit second edge");
    frame(7, 1, 0, 1, 0, 1, 32'h0000_0053, 32'h0000_0061, 0, 0, 0, 0, "R3 even parity");
    frame(13, 1, 1, 0, 1, 0, 32'h0000_1ABC, 32'h0000_0F0F, 1, 0, 0, 0, "R4 odd parity error");
    frame(31, 1, 1, 1, 1, 0, 32'h7000_0001, 32'h5555_AAAA, 1, 0, 0, 0, "R4 odd parity 31 error second edge");
    frame(12, 1, 0, 0, 0, 0, 32'h0000_0FFF, 32'h0000_0800, 0, 0, 0, 0, "R4 flag clears");
    testIdleModes();
    frame(3, 0, 0, 1, 0, 1, 32'h0000_00C3, 32'h0000_0091, 0, 0, 0, 0, "R1 clamp low");
    frame(63, 1, 0, 0, 0, 0, 32'hFFFF_0000, 32'h0F0F_F0F0, 0, 0, 0, 0, "R1 clamp high");
    frame(10, 0, 0, 1, 0, 0, 32'h0000_0255, 32'h0000_01AA, 0, 1, 0, 0, "R9 mid-frame changes ignored");
    nLen = 9; nPar = 1; nOdd = 1; nMsb = 0; nS2 = 1; nCkh = 0; nWord = 32'h0000_0135;
    frame(16, 0, 0, 1, 0, 0, 32'h0000_8001, 32'h0000_7FFE, 0, 0, 1, 0, "R10 chain first");
    frame(9, 1, 1, 0, 1, 0, 32'h0000_0135, 32'h0000_00C4, 0, 0, 0, 1, "R10 chain second");
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule